// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block decides, for every external bus access, which of three external devices is addressed and which bus attributes that access must use. Each channel holds a base address and a power-of-two region size. It also holds three attributes: the bus width (8 or 16 bit), a wait-state count, and whether address and data share pins (multiplexed) or use separate pins. The block compares the 24-bit access address against all three regions at once. It drives the active-low select of the winning channel and passes that channel's attributes on to a bus cycle generator.

Software programs the channels through a small write port. Each channel has two registers: a base register, which holds address bits 23:8, and an attribute register. When regions overlap, the lowest-numbered channel wins. When an access falls outside every region, no select is driven and a fixed default attribute set is presented. The selects and attributes are registered, so they appear one clock after the address strobe. The block does not generate the bus cycle, count wait states or multiplex the pins.

Top module: `csel_decoder`

## Requirements
- R1: While reset is held and right after its release, all three `cs_n` outputs are high and the attribute outputs show the default set: `bus_wide`=1, `bus_waits`=3, `bus_muxed`=1.
- R2: A select is driven low only when `acc_strobe` and `acc_ext` were both high on the previous rising clock edge and the address lay inside that channel's region. The outputs are registered, so they change on the edge after the strobe is sampled. In a cycle that follows an edge with `acc_strobe` low, all selects are high.
- R3: The size code in attribute bits [3:0] selects a region of 256 << code bytes for codes 0 to 11 (256 B to 512 KB). Codes 12 to 15 all select 2 MB.
- R4: A region covers exactly the addresses whose bits at and above log2(size) equal the same bits of {base register, 8'h00}. Base bits below the region size are ignored.
- R5: At most one select is low at any time. When several regions contain the address, channel 0 beats channel 1 and channel 1 beats channel 2.
- R6: When no region contains the address, all selects stay high and the default attribute set (16-bit, 3 wait states, multiplexed) is output.
- R7: With a select low, `bus_wide`, `bus_waits` and `bus_muxed` equal the fields of that channel's attribute register. The fields are bits [7:4] for the wait count, bit [8] for the width (1 = 16-bit) and bit [9] for the mode (1 = multiplexed).
- R8: When `cfg_we` is high on a rising edge, `cfg_wdata` is written to the register at `cfg_addr` = {channel[1:0], kind}, where kind 0 is the base register and kind 1 the attribute register. The new value applies from the next access. Writes with channel = 3 change no channel.
- R9: An access with `acc_ext` low, even with `acc_strobe` high, drives no select and leaves the default attributes on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | {channel, kind}: kind 0 = base, 1 = attributes |
| cfg_wdata | input | 16 | Write data |
| acc_strobe | input | 1 | Address strobe, access address valid |
| acc_ext | input | 1 | The access targets the external bus |
| acc_addr | input | 24 | Access byte address |
| cs_n | output | 3 | Active-low chip selects, one per channel |
| bus_wide | output | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| bus_waits | output | 4 | Wait states for the access |
| bus_muxed | output | 1 | 1 = multiplexed address/data |

## Verification
The hardest situations to reach are the two in which a region's real extent differs from what the written base suggests. In one, a reserved size code silently widens the region to 2 MB. In the other, a misaligned base has low bits that the decoder must drop. Both are bound up with overlaps, where a lower channel must mask a higher one. The bench gets there by reprogramming channel 0 between probes. It moves channel 0 from 64 KB to a reserved code and then down to 256 B, and it grows channel 1 to 512 KB. Each time it probes addresses just inside and just outside the new edges, so the winner changes in ways that only the correct mask and priority can produce. A write to the unused channel slot is followed by probes of every live channel.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int ADDR_W    = 24;
  localparam int BASE_LSB  = 8;
  localparam int BASE_W    = ADDR_W - BASE_LSB;
  localparam int SIZE_W    = 4;
  localparam int WAIT_W    = 4;
  localparam int CFG_DW    = 16;
  localparam int STEP_LAST = 11;
  localparam int BIG_SHIFT = 21;
  localparam int SHIFT_W   = $clog2(ADDR_W + 1);

  typedef struct packed {
    logic              muxed;
    logic              wide;
    logic [WAIT_W-1:0] waits;
    logic [SIZE_W-1:0] size;
  } chan_attr_t;

  localparam int ATTR_W = $bits(chan_attr_t);

  localparam chan_attr_t ATTR_DEFAULT = '{muxed: 1'b1, wide: 1'b1,
                                          waits: WAIT_W'(3), size: '0};

  // Number of low address bits that lie inside the region.
  function automatic logic [SHIFT_W-1:0] span_bits(input logic [SIZE_W-1:0] code);
    if (int'(code) <= STEP_LAST)
      span_bits = SHIFT_W'(BASE_LSB + int'(code));
    else
      span_bits = SHIFT_W'(BIG_SHIFT);
  endfunction

  // Ones on every address bit that must equal the base.
  function automatic logic [ADDR_W-1:0] keep_mask(input logic [SIZE_W-1:0] code);
    logic [ADDR_W-1:0] low;
    low = (ADDR_W'(1) << span_bits(code)) - ADDR_W'(1);
    keep_mask = ~low;
  endfunction

  function automatic logic in_region(input logic [ADDR_W-1:0] addr,
                                     input logic [BASE_W-1:0] base,
                                     input logic [SIZE_W-1:0] code);
    logic [ADDR_W-1:0] diff;
    diff = addr ^ {base, {BASE_LSB{1'b0}}};
    in_region = ((diff & keep_mask(code)) == '0);
  endfunction

endpackage

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
  import csel_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1,
  localparam int CA_W  = CH_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [CA_W-1:0]               waddr,
  input  logic [CFG_DW-1:0]             wdata,
  output logic [NUM_CH-1:0][BASE_W-1:0] base_q,
  output chan_attr_t [NUM_CH-1:0]       attr_q
);

  logic [CH_W-1:0] wr_chan;
  logic            wr_kind;

  assign wr_chan = waddr[CA_W-1:1];
  assign wr_kind = waddr[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_ch;
    logic base_we;
    logic attr_we;

    assign sel_ch  = we && (wr_chan == CH_W'(c));
    assign base_we = sel_ch && !wr_kind;
    assign attr_we = sel_ch && wr_kind;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[c] <= '0;
      end else if (base_we) begin
        base_q[c] <= wdata[BASE_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        attr_q[c] <= ATTR_DEFAULT;
      end else if (attr_we) begin
        attr_q[c] <= chan_attr_t'(wdata[ATTR_W-1:0]);
      end
    end
  end

endmodule

// File: rtl/csel_window_cmp.sv
module csel_window_cmp
  import csel_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  output logic              hit
);

  assign hit = in_region(addr, base, size);

endmodule

// File: rtl/csel_pick.sv
module csel_pick
  import csel_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                    qualify,
  input  logic [NUM_CH-1:0]       hit,
  input  chan_attr_t [NUM_CH-1:0] attr,
  output logic [NUM_CH-1:0]       grant,
  output chan_attr_t              attr_sel
);

  always_comb begin
    logic taken;
    taken    = 1'b0;
    grant    = '0;
    attr_sel = ATTR_DEFAULT;
    for (int c = 0; c < NUM_CH; c++) begin
      if (qualify && hit[c] && !taken) begin
        taken    = 1'b1;
        grant[c] = 1'b1;
        attr_sel = attr[c];
      end
    end
  end

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1,
  localparam int CA_W  = CH_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CA_W-1:0]    cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  input  logic               acc_strobe,
  input  logic               acc_ext,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic [NUM_CH-1:0]  cs_n,
  output logic               bus_wide,
  output logic [WAIT_W-1:0]  bus_waits,
  output logic               bus_muxed
);

  logic [NUM_CH-1:0][BASE_W-1:0] base_q;
  chan_attr_t [NUM_CH-1:0]       attr_q;
  logic [NUM_CH-1:0]             chan_hit;
  logic [NUM_CH-1:0]             chan_grant;
  chan_attr_t                    attr_pick;
  logic                          acc_live;

  assign acc_live = acc_strobe && acc_ext;

  csel_cfg_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .waddr  (cfg_addr),
    .wdata  (cfg_wdata),
    .base_q (base_q),
    .attr_q (attr_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    csel_window_cmp u_cmp (
      .addr (acc_addr),
      .base (base_q[c]),
      .size (attr_q[c].size),
      .hit  (chan_hit[c])
    );
  end

  csel_pick #(.NUM_CH(NUM_CH)) u_pick (
    .qualify  (acc_live),
    .hit      (chan_hit),
    .attr     (attr_q),
    .grant    (chan_grant),
    .attr_sel (attr_pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n      <= '1;
      bus_wide  <= ATTR_DEFAULT.wide;
      bus_waits <= ATTR_DEFAULT.waits;
      bus_muxed <= ATTR_DEFAULT.muxed;
    end else begin
      cs_n      <= ~chan_grant;
      bus_wide  <= attr_pick.wide;
      bus_waits <= attr_pick.waits;
      bus_muxed <= attr_pick.muxed;
    end
  end

endmodule

// File: rtl/csel_checks.sv
module csel_checks
  import csel_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_strobe,
  input logic              acc_ext,
  input logic [NUM_CH-1:0] cs_n,
  input logic              bus_wide,
  input logic [WAIT_W-1:0] bus_waits,
  input logic              bus_muxed,
  input logic [NUM_CH-1:0] chan_hit,
  input logic [NUM_CH-1:0] chan_grant
);

  p_single_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_strobe && acc_ext) |=> (cs_n == '1));

  p_select_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && acc_ext) |=> (cs_n == ~$past(chan_grant)));

  p_low_channel_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && acc_ext && chan_hit[0]) |=> !cs_n[0]);

  p_default_attrs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == '1) |-> (bus_wide && bus_muxed && (bus_waits == WAIT_W'(3))));

endmodule

bind csel_decoder csel_checks #(.NUM_CH(NUM_CH)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_strobe (acc_strobe),
  .acc_ext    (acc_ext),
  .cs_n       (cs_n),
  .bus_wide   (bus_wide),
  .bus_waits  (bus_waits),
  .bus_muxed  (bus_muxed),
  .chan_hit   (chan_hit),
  .chan_grant (chan_grant)
);

// File: tb/csel_decoder_test.sv
`timescale 1ns/1ps
module csel_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        acc_strobe = 1'b0;
  logic        acc_ext = 1'b0;
  logic [23:0] acc_addr = '0;
  logic [2:0]  cs_n;
  logic        bus_wide;
  logic [3:0]  bus_waits;
  logic        bus_muxed;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csel_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_strobe(acc_strobe), .acc_ext(acc_ext),
    .acc_addr(acc_addr), .cs_n(cs_n), .bus_wide(bus_wide),
    .bus_waits(bus_waits), .bus_muxed(bus_muxed)
  );

  // {ext, addr, cs_n, wide, waits, muxed}
  localparam logic [33:0] VEC [10] = '{
    {1'b1, 24'h010000, 3'b110, 1'b0, 4'd1,  1'b0},
    {1'b1, 24'h01FFFF, 3'b110, 1'b0, 4'd1,  1'b0},
    {1'b1, 24'h020000, 3'b111, 1'b1, 4'd3,  1'b1},
    {1'b1, 24'h018100, 3'b110, 1'b0, 4'd1,  1'b0},
    {1'b1, 24'h200000, 3'b011, 1'b1, 4'd15, 1'b1},
    {1'b1, 24'h3FFFFF, 3'b011, 1'b1, 4'd15, 1'b1},
    {1'b1, 24'h400000, 3'b111, 1'b1, 4'd3,  1'b1},
    {1'b1, 24'h00FFFF, 3'b111, 1'b1, 4'd3,  1'b1},
    {1'b0, 24'h010000, 3'b111, 1'b1, 4'd3,  1'b1},
    {1'b1, 24'h1FFFFF, 3'b111, 1'b1, 4'd3,  1'b1}
  };

  task automatic check_out(input string tag, input logic [2:0] e_cs,
                           input logic e_w, input logic [3:0] e_ws, input logic e_m);
    checks++;
    if (cs_n !== e_cs || bus_wide !== e_w || bus_waits !== e_ws || bus_muxed !== e_m) begin
      fails++;
      $display("FAIL %s: got cs_n=%b wide=%b waits=%0d muxed=%b, expected cs_n=%b wide=%b waits=%0d muxed=%b",
               tag, cs_n, bus_wide, bus_waits, bus_muxed, e_cs, e_w, e_ws, e_m);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input string tag, input logic ext, input logic [23:0] a,
                       input logic [2:0] e_cs, input logic e_w,
                       input logic [3:0] e_ws, input logic e_m);
    @(negedge clk);
    acc_strobe = 1'b1; acc_ext = ext; acc_addr = a;
    @(negedge clk);
    check_out(tag, e_cs, e_w, e_ws, e_m);
    acc_strobe = 1'b0; acc_ext = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_out("R1 in reset", 3'b111, 1'b1, 4'd3, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after reset", 3'b111, 1'b1, 4'd3, 1'b1);

    // R8 programming: ch0 64 KB at 0x010000, ch1 8 KB at 0x018000,
    // ch2 2 MB with misaligned base 0x234500 (R4).
    cfg_write(3'd0, 16'h0100);
    cfg_write(3'd1, 16'h0018);
    cfg_write(3'd2, 16'h0180);
    cfg_write(3'd3, 16'h0175);
    cfg_write(3'd4, 16'h2345);
    cfg_write(3'd5, 16'h03FC);

    for (int i = 0; i < 10; i++) begin
      probe($sformatf("R2 R4 R5 R6 R7 R9 vector %0d", i), VEC[i][33], VEC[i][32:9],
            VEC[i][8:6], VEC[i][5], VEC[i][4:1], VEC[i][0]);
    end

    // R2: strobe dropped after a hit clears the select
    probe("R2 hit before idle", 1'b1, 24'h010010, 3'b110, 1'b0, 4'd1, 1'b0);
    @(negedge clk);
    check_out("R2 idle cycle", 3'b111, 1'b1, 4'd3, 1'b1);

    // R3: reserved code 13 acts as 2 MB, base 0x010000 masked to 0
    cfg_write(3'd1, 16'h001D);
    probe("R3 reserved code upper", 1'b1, 24'h1F0000, 3'b110, 1'b0, 4'd1, 1'b0);
    probe("R3 reserved code overlap", 1'b1, 24'h018100, 3'b110, 1'b0, 4'd1, 1'b0);

    // R3: code 0 is 256 bytes
    cfg_write(3'd1, 16'h0010);
    probe("R3 256B last byte", 1'b1, 24'h0100FF, 3'b110, 1'b0, 4'd1, 1'b0);
    probe("R3 256B just past", 1'b1, 24'h010100, 3'b111, 1'b1, 4'd3, 1'b1);
    probe("R7 channel 1 attrs", 1'b1, 24'h018100, 3'b101, 1'b1, 4'd7, 1'b0);

    // R3 R4: code 11 is 512 KB, base 0x018000 masked to 0
    cfg_write(3'd3, 16'h017B);
    probe("R3 512KB region", 1'b1, 24'h070000, 3'b101, 1'b1, 4'd7, 1'b0);
    probe("R4 512KB past end", 1'b1, 24'h080000, 3'b111, 1'b1, 4'd3, 1'b1);
    probe("R5 ch0 inside ch1", 1'b1, 24'h010000, 3'b110, 1'b0, 4'd1, 1'b0);

    // R8: writes to the unused channel slot change nothing
    cfg_write(3'd6, 16'h0000);
    cfg_write(3'd7, 16'h029C);
    probe("R8 ch2 unchanged", 1'b1, 24'h250000, 3'b011, 1'b1, 4'd15, 1'b1);
    probe("R8 ch0 unchanged", 1'b1, 24'h010000, 3'b110, 1'b0, 4'd1, 1'b0);
    probe("R8 ch1 unchanged", 1'b1, 24'h060000, 3'b101, 1'b1, 4'd7, 1'b0);

    finish_run();
  end

endmodule